// File: doc/BRIEF.md
# Table-Encoded Gated Clock-Enable Divider

This block turns a free-running clock into a train of single-cycle enable pulses, one pulse every N input cycles. N is not programmed directly. A 4-bit selector code is looked up in a fixed, irregular ratio table. The table is chosen at build time by the parameter `TABLE_SEL`, and each table leaves some codes unused. A control word written through a simple write port holds the selector code and a stop bit. Setting the stop bit silences the output, and clearing it lets the output run. A read port returns the code as last written, the stop bit, and a sticky flag. The flag records that an unused code was written at some point.

The output is meant to drive clock-enable inputs of downstream logic that runs on the same clock. A code written while the divider runs does not take effect at once. The running period always finishes at its old length, so no shortened period is ever produced. An unused code leaves the divider on the last good ratio.

Top module: `tabdiv_top`

## Requirements
- R1: While running, `tick` is high for exactly one cycle in every N cycles, where N is the ratio that the table gives for the active code.
- R2: With `TABLE_SEL`=0, the valid codes map to these ratios: 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. Every other code is unused.
- R3: With `TABLE_SEL`=1, the mapping is that of R2, plus code 0→2.
- R4: With `TABLE_SEL`=2, the valid codes map to 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→10. Every other code is unused.
- R5: Writing an unused code keeps the previous ratio in effect. It also sets the error flag `rd_data[5]`, which stays set until reset.
- R6: A ratio change written while running takes effect only after the current period ends. The period in progress keeps its old length.
- R7: The stop bit is `wr_data[4]`, and 1 means stopped. A stop takes effect from the cycle after its write edge, and no tick occurs while stopped. When a write clears the stop bit, the divider counts from zero with the newest ratio. Its first tick then falls N cycles after that write's clock edge.
- R8: After synchronous reset the stop bit is 1 and the error flag is 0. The code is the smallest valid code of the selected table (1, 0 and 5 for tables 0, 1 and 2), and `tick` is low.
- R9: `rd_data[3:0]` returns the code as last written, valid or not. `rd_data[4]` returns the stop bit and `rd_data[5]` returns the error flag. A write loads the code from `wr_data[3:0]` and the stop bit from `wr_data[4]` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Loads the control word in this cycle |
| wr_data | input | 5 | {stop bit, selector code} |
| rd_data | output | 6 | {error flag, stop bit, code as written} |
| tick | output | 1 | Single-cycle enable pulse |

## Verification
The assertions assume that every ratio in the selected table is at least 2, so a pulse is always followed by a low cycle. They also assume that `rst` is driven from the same clock, so the counter and the control word are never observed mid-reset. The stimulus changes `wr_en` and `wr_data` only on falling edges, and issues each write as a single-cycle pulse. It exercises every one of the 16 codes, writes in the middle of long periods, and sets and clears the stop bit at several phases of the count. Three instances, one per table, receive the same stimulus, so each code is valid for some tables and unused for others in the same run.

// File: rtl/tabdiv_pkg.sv
package tabdiv_pkg;

    localparam int SEL_W   = 4;
    localparam int RATIO_W = 6;

    typedef struct packed {
        logic               valid;
        logic [RATIO_W-1:0] ratio;
    } ratio_t;

    typedef enum logic [1:0] {
        TBL_BASE  = 2'd0,
        TBL_EXT   = 2'd1,
        TBL_UPPER = 2'd2
    } tbl_e;

    // Base table, optionally with code 0 mapped to 2.
    function automatic ratio_t ratio_base(input logic [SEL_W-1:0] c, input logic zero_ok);
        ratio_t r;
        r.valid = 1'b1;
        case (c)
            4'd0:    begin r.ratio = 6'd2;  r.valid = zero_ok; end
            4'd1:    r.ratio = 6'd3;
            4'd2:    r.ratio = 6'd4;
            4'd3:    r.ratio = 6'd6;
            4'd4:    r.ratio = 6'd8;
            4'd5:    r.ratio = 6'd12;
            4'd6:    r.ratio = 6'd16;
            4'd7:    r.ratio = 6'd18;
            4'd8:    r.ratio = 6'd24;
            4'd10:   r.ratio = 6'd36;
            4'd11:   r.ratio = 6'd48;
            default: begin r.ratio = 6'd0; r.valid = 1'b0; end
        endcase
        return r;
    endfunction

    // Upper table: codes below 5 unused, code 12 adds ratio 10.
    function automatic ratio_t ratio_upper(input logic [SEL_W-1:0] c);
        ratio_t r;
        if (c == 4'd12) begin
            r.valid = 1'b1;
            r.ratio = 6'd10;
        end else if (c < 4'd5) begin
            r.valid = 1'b0;
            r.ratio = 6'd0;
        end else begin
            r = ratio_base(c, 1'b0);
        end
        return r;
    endfunction

    function automatic ratio_t ratio_lookup(input tbl_e t, input logic [SEL_W-1:0] c);
        ratio_t r;
        case (t)
            TBL_EXT:   r = ratio_base(c, 1'b1);
            TBL_UPPER: r = ratio_upper(c);
            default:   r = ratio_base(c, 1'b0);
        endcase
        return r;
    endfunction

    function automatic logic [SEL_W-1:0] first_valid(input tbl_e t);
        logic [SEL_W-1:0] found;
        logic             hit;
        found = '0;
        hit   = 1'b0;
        for (int i = 0; i < (1 << SEL_W); i++) begin
            if (!hit && ratio_lookup(t, SEL_W'(i)).valid) begin
                found = SEL_W'(i);
                hit   = 1'b1;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/tabdiv_lut.sv
module tabdiv_lut
    import tabdiv_pkg::*;
#(
    parameter int TABLE_SEL = 0
) (
    input  logic [SEL_W-1:0] code,
    output ratio_t           entry
);
    localparam tbl_e TBL = tbl_e'(TABLE_SEL[1:0]);

    generate
        if (TBL == TBL_UPPER) begin : g_upper
            always_comb entry = ratio_upper(code);
        end else if (TBL == TBL_EXT) begin : g_ext
            always_comb entry = ratio_base(code, 1'b1);
        end else begin : g_base
            always_comb entry = ratio_base(code, 1'b0);
        end
    endgenerate

    always_comb begin
        if (entry.valid) begin
            assert (entry.ratio >= RATIO_W'(2))
                else $error("p_ratio_min_r1: valid ratio below 2");
        end
    end
endmodule

// File: rtl/tabdiv_ctrl.sv
module tabdiv_ctrl
    import tabdiv_pkg::*;
#(
    parameter int TABLE_SEL = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_code,
    input  logic               wr_stop,
    output logic               stop_q,
    output logic               err_q,
    output logic [SEL_W-1:0]   code_q,
    output logic [RATIO_W-1:0] pend_d
);
    localparam tbl_e             TBL       = tbl_e'(TABLE_SEL[1:0]);
    localparam logic [SEL_W-1:0] RST_CODE  = first_valid(TBL);
    localparam ratio_t           RST_ENTRY = ratio_lookup(TBL, RST_CODE);

    ratio_t             wr_entry;
    logic [RATIO_W-1:0] pend_q;

    tabdiv_lut #(.TABLE_SEL(TABLE_SEL)) u_lut (
        .code  (wr_code),
        .entry (wr_entry)
    );

    // Ratio that becomes pending after this edge; the counter samples it.
    always_comb begin
        pend_d = pend_q;
        if (wr_en && wr_entry.valid) pend_d = wr_entry.ratio;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RST_CODE;
            stop_q <= 1'b1;
            err_q  <= 1'b0;
            pend_q <= RST_ENTRY.ratio;
        end else begin
            pend_q <= pend_d;
            if (wr_en) begin
                code_q <= wr_code;
                stop_q <= wr_stop;
                if (!wr_entry.valid) err_q <= 1'b1;
            end
        end
    end

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    p_bad_code_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_entry.valid) |=> $stable(pend_q));
endmodule

// File: rtl/tabdiv_count.sv
module tabdiv_count
    import tabdiv_pkg::*;
#(
    parameter int                 CNT_W     = RATIO_W,
    parameter logic [RATIO_W-1:0] RST_RATIO = 6'd3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop,
    input  logic [RATIO_W-1:0] next_ratio,
    output logic               tick
);
    logic [CNT_W-1:0]   cnt_q;
    logic [RATIO_W-1:0] cur_q;
    logic               at_end;

    assign at_end = (cnt_q == CNT_W'(cur_q - RATIO_W'(1)));
    assign tick   = !stop && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= RST_RATIO;
        end else if (stop || at_end) begin
            cnt_q <= '0;
            cur_q <= next_ratio;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    p_no_tick_stopped_r7: assert property (@(posedge clk) disable iff (rst)
        stop |-> !tick);

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        RATIO_W'(cnt_q) < cur_q);

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_ratio_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_q) |-> (cnt_q == '0));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stop) |-> (cnt_q == '0));
endmodule

// File: rtl/tabdiv_top.sv
module tabdiv_top
    import tabdiv_pkg::*;
#(
    parameter int TABLE_SEL = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W:0]     wr_data,
    output logic [SEL_W+1:0]   rd_data,
    output logic               tick
);
    localparam tbl_e   TBL       = tbl_e'(TABLE_SEL[1:0]);
    localparam ratio_t RST_ENTRY = ratio_lookup(TBL, first_valid(TBL));

    logic               stop_q;
    logic               err_q;
    logic [SEL_W-1:0]   code_q;
    logic [RATIO_W-1:0] pend_d;

    tabdiv_ctrl #(.TABLE_SEL(TABLE_SEL)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_code (wr_data[SEL_W-1:0]),
        .wr_stop (wr_data[SEL_W]),
        .stop_q  (stop_q),
        .err_q   (err_q),
        .code_q  (code_q),
        .pend_d  (pend_d)
    );

    tabdiv_count #(.CNT_W(RATIO_W), .RST_RATIO(RST_ENTRY.ratio)) u_count (
        .clk        (clk),
        .rst        (rst),
        .stop       (stop_q),
        .next_ratio (pend_d),
        .tick       (tick)
    );

    assign rd_data = {err_q, stop_q, code_q};

    p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data[SEL_W] && !rd_data[SEL_W+1] && !tick));
endmodule

// File: tb/tabdiv_top_bench.sv
module tabdiv_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = 5'd0;
    logic [5:0] rd [3];
    logic       tk [3];

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    string tag = "R8";

    always #2 clk = ~clk;

    tabdiv_top #(.TABLE_SEL(0)) u_tabdiv_top   (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[0]), .tick(tk[0]));
    tabdiv_top #(.TABLE_SEL(1)) u_tabdiv_top_b (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[1]), .tick(tk[1]));
    tabdiv_top #(.TABLE_SEL(2)) u_tabdiv_top_c (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd[2]), .tick(tk[2]));

    // Requirement tables R2, R3, R4; 0 means unused code.
    function automatic int ref_ratio(input int t, input int c);
        int r;
        case (c)
            1: r = 3;   2: r = 4;   3: r = 6;   4: r = 8;
            5: r = 12;  6: r = 16;  7: r = 18;  8: r = 24;
            10: r = 36; 11: r = 48;
            default: r = 0;
        endcase
        if (t == 1 && c == 0) r = 2;
        if (t == 2) begin
            if (c < 5) r = 0;
            if (c == 12) r = 10;
        end
        return r;
    endfunction

    int m_code [3];
    int m_stop [3];
    int m_err  [3];
    int m_pend [3];
    int m_cur  [3];
    int m_cnt  [3];

    always @(posedge clk) begin
        for (int t = 0; t < 3; t++) begin
            if (rst) begin
                m_code[t] = (t == 0) ? 1 : (t == 1) ? 0 : 5;
                m_stop[t] = 1;
                m_err[t]  = 0;
                m_pend[t] = ref_ratio(t, m_code[t]);
                m_cur[t]  = m_pend[t];
                m_cnt[t]  = 0;
            end else begin
                int np;
                int ns;
                np = m_pend[t];
                ns = m_stop[t];
                if (wr_en) begin
                    m_code[t] = int'(wr_data[3:0]);
                    ns = int'(wr_data[4]);
                    if (ref_ratio(t, m_code[t]) != 0) np = ref_ratio(t, m_code[t]);
                    else m_err[t] = 1;
                end
                if (m_stop[t] != 0 || m_cnt[t] == m_cur[t] - 1) begin
                    m_cnt[t] = 0;
                    m_cur[t] = np;
                end else begin
                    m_cnt[t] = m_cnt[t] + 1;
                end
                m_pend[t] = np;
                m_stop[t] = ns;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int t = 0; t < 3; t++) begin
                logic       exp_tk;
                logic [5:0] exp_rd;
                exp_tk = (m_stop[t] == 0) && (m_cnt[t] == m_cur[t] - 1);
                exp_rd = {m_err[t][0], m_stop[t][0], 4'(m_code[t])};
                checks++;
                if (tk[t] !== exp_tk) begin
                    errors++;
                    $display("FAIL %s tick table%0d t=%0t actual=%b expected=%b", tag, t, $time, tk[t], exp_tk);
                end
                checks++;
                if (rd[t] !== exp_rd) begin
                    errors++;
                    $display("FAIL %s rd_data table%0d t=%0t actual=%h expected=%h", tag, t, $time, rd[t], exp_rd);
                end
            end
        end
    end

    task automatic wr(input logic stop, input logic [3:0] code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {stop, code};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        tag = "R8";
        idle(6);

        tag = "R9";
        wr(1'b1, 4'd7);
        idle(3);
        wr(1'b1, 4'd13);
        idle(3);

        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        tag = "R1 R2 R3 R4 R5";
        for (int c = 0; c < 16; c++) begin
            wr(1'b1, 4'(c));
            wr(1'b0, 4'(c));
            idle(110);
        end

        tag = "R6";
        wr(1'b0, 4'd11);
        idle(30);
        wr(1'b0, 4'd1);
        idle(100);
        wr(1'b0, 4'd8);
        idle(5);
        wr(1'b0, 4'd6);
        idle(60);

        tag = "R7";
        wr(1'b1, 4'd8);
        idle(20);
        wr(1'b0, 4'd8);
        idle(60);
        for (int k = 0; k < 6; k++) begin
            idle(k * 3);
            wr(1'b1, 4'd3);
            idle(4);
            wr(1'b0, 4'd4);
            idle(20);
        end
        wr(1'b1, 4'd2);
        wr(1'b0, 4'd12);
        idle(50);

        tag = "R5";
        wr(1'b0, 4'd15);
        idle(40);
        wr(1'b0, 4'd6);
        idle(40);

        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        tag = "R8";
        idle(10);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule